// File: doc/BRIEF.md
# Two-Phase Pulse-Count and Residue-Time Pixel Counter

This block is the digital back end of a pulse-frequency-modulation pixel. While a frame integrates, each reset pulse from the pixel comparator adds one to a shared counter. The frame-end strobe closes this coarse phase. At that point the count is latched into a coarse result register and the counter restarts from zero.

Charge keeps integrating after the strobe. The same counter then advances once per master-clock cycle until the comparator fires again. Its value at that trigger is the residue time, which is latched into a residue register. A one-cycle done flag marks the moment both results are valid. The closing trigger also starts the next frame's coarse counting at once.

Downstream logic combines the coarse count, the residue time and the integration time to get a finer charge estimate. The comparator output is asynchronous to the clock, so it is resynchronized and edge-detected before it is used.

Top module: `pfm_two_phase_counter`

## Requirements
- R1: After reset, coarse_count, residue_count, residue_ovf and frame_done are all zero.
- R2: In the coarse phase, each rising edge of comp_pulse adds exactly one to the count, whatever the pulse width. This holds for pulses high for at least two clocks and low for at least two clocks.
- R3: When frame_end is sampled high in the coarse phase, coarse_count takes the count on the next edge. The count includes a synchronized comparator edge detected in that same cycle. The counter then restarts at zero.
- R4: The coarse count saturates at 16383 and does not wrap.
- R5: Let a rising edge of comp_pulse first be sampled at the k-th clock edge after the edge that sampled frame_end (k >= 1). Then residue_count becomes k+1, which counts the two synchronizer stages.
- R6: If the residue count would exceed 2047, it holds at 2047 and residue_ovf is 1 for that frame. Otherwise residue_ovf is 0.
- R7: frame_done is high for exactly one cycle. residue_count and residue_ovf change only on the edge that raises frame_done.
- R8: frame_end is ignored during the residue phase.
- R9: The trigger that ends the residue phase is not counted into the next frame's coarse count. Coarse counting resumes immediately after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| comp_pulse | input | 1 | Comparator reset pulse, asynchronous |
| frame_end | input | 1 | End-of-integration strobe, synchronous |
| coarse_count | output | 14 | Latched pulse count of the last frame |
| residue_count | output | 11 | Latched residue time in clock cycles |
| residue_ovf | output | 1 | Residue saturated for the last frame |
| frame_done | output | 1 | One-cycle flag: both results valid |

## Verification
Two cases are hardest to reach from the ports. One is a synchronized comparator edge that falls in exactly the cycle the frame-end strobe is sampled. The bench gets there by raising comp_pulse two falling edges before it raises frame_end, which lines up the synchronizer delay with the strobe.

The saturation cases need long runs. More than 16383 coarse pulses are driven at four clocks each, and residue waits of 2045, 2046 and beyond are used to hit the 2047 boundary on both sides. A stray strobe inside the residue window checks that the residue value does not move.

// File: rtl/pfm_two_phase_counter.sv
module pfm_two_phase_counter #(
  parameter int CW = 14,
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          comp_pulse,
  input  logic          frame_end,
  output logic [CW-1:0] coarse_count,
  output logic [RW-1:0] residue_count,
  output logic          residue_ovf,
  output logic          frame_done
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] RMAX = CW'({RW{1'b1}});

  logic          s1, s2, s3;
  logic          trig;
  logic          in_res;
  logic          ovf_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {comp_pulse, s1, s2};

  assign trig    = s2 & ~s3;
  assign cnt_inc = (cnt == CMAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_res        <= 1'b0;
      cnt           <= '0;
      ovf_q         <= 1'b0;
      coarse_count  <= '0;
      residue_count <= '0;
      residue_ovf   <= 1'b0;
      frame_done    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!in_res) begin
        if (frame_end) begin
          coarse_count <= trig ? cnt_inc : cnt;
          cnt          <= '0;
          ovf_q        <= 1'b0;
          in_res       <= 1'b1;
        end else if (trig) begin
          cnt <= cnt_inc;
        end
      end else begin
        if (trig) begin
          residue_count <= cnt[RW-1:0];
          residue_ovf   <= ovf_q;
          frame_done    <= 1'b1;
          cnt           <= '0;
          in_res        <= 1'b0;
        end else if (cnt == RMAX) begin
          ovf_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
endmodule

// File: rtl/pfm_two_phase_counter_chk.sv
module pfm_two_phase_counter_chk #(
  parameter int CW = 14,
  parameter int RW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end,
  input logic          in_res,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] coarse_count,
  input logic [RW-1:0] residue_count,
  input logic          residue_ovf,
  input logic          frame_done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(residue_count) && $stable(residue_ovf))); // R7
  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && residue_ovf) |-> (residue_count == {RW{1'b1}})); // R6
  AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_res |-> (cnt <= CW'({RW{1'b1}}))); // R6
  AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(frame_end) && !$past(in_res)) |-> $stable(coarse_count)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!in_res && cnt == '0)); // R9
endmodule

bind pfm_two_phase_counter pfm_two_phase_counter_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .in_res(in_res), .cnt(cnt),
  .coarse_count(coarse_count), .residue_count(residue_count),
  .residue_ovf(residue_ovf), .frame_done(frame_done)
);

// File: tb/pfm_two_phase_counter_bench.sv
module pfm_two_phase_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp_pulse = 1'b0;
  logic        frame_end = 1'b0;
  logic [13:0] coarse_count;
  logic [10:0] residue_count;
  logic        residue_ovf;
  logic        frame_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct { int coarse; int res; bit ovf; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pfm_two_phase_counter u_pfm_two_phase_counter (
    .clk(clk), .rst_n(rst_n), .comp_pulse(comp_pulse), .frame_end(frame_end),
    .coarse_count(coarse_count), .residue_count(residue_count),
    .residue_ovf(residue_ovf), .frame_done(frame_done)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && frame_done) begin
    exp_t e;
    if (q.size() == 0) begin
      check("R7 unexpected done", 1, 0);
    end else begin
      e = q.pop_front();
      check({e.tag, " coarse"}, coarse_count, e.coarse);
      check({e.tag, " residue"}, residue_count, e.res);
      check({e.tag, " ovf"}, residue_ovf, e.ovf);
    end
    @(negedge clk);
    check("R7 done width", frame_done, 0);
  end

  task automatic pulse(int hi);
    comp_pulse = 1'b1;
    repeat (hi) @(negedge clk);
    comp_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(string tag, int np, int hi, bit edge_p, int w, bit stray);
    exp_t e;
    int tot;
    tot = np + (edge_p ? 1 : 0);
    e.coarse = (tot > 16383) ? 16383 : tot;
    e.res    = (w + 2 > 2047) ? 2047 : w + 2;
    e.ovf    = (w + 2 > 2047);
    e.tag    = tag;
    q.push_back(e);
    for (int i = 0; i < np; i++) pulse(hi);
    repeat (2) @(negedge clk);
    if (edge_p) begin
      comp_pulse = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    if (edge_p) begin
      comp_pulse = 1'b0;
      w = w - 0;
    end
    for (int i = 0; i < w; i++) begin
      frame_end = stray && (i == w / 2);
      @(negedge clk);
    end
    frame_end = 1'b0;
    comp_pulse = 1'b1;
    repeat (2) @(negedge clk);
    comp_pulse = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 coarse", coarse_count, 0);
    check("R1 residue", residue_count, 0);
    check("R1 ovf", residue_ovf, 0);
    check("R1 done", frame_done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame("R2 R5 short", 5, 2, 0, 0, 0);
    run_frame("R2 long pulses", 7, 9, 0, 10, 0);
    run_frame("R9 zero pulses", 0, 2, 0, 3, 0);
    run_frame("R3 edge pulse", 4, 2, 1, 6, 0);
    run_frame("R8 stray strobe", 3, 2, 0, 40, 1);
    run_frame("R6 at max", 2, 2, 0, 2045, 0);
    run_frame("R6 just over", 1, 2, 0, 2046, 0);
    run_frame("R6 far over", 0, 2, 0, 2600, 0);
    run_frame("R4 saturate", 16390, 1, 0, 20, 0);
    run_frame("R9 after sat", 6, 2, 0, 1, 0);
    repeat (10) @(negedge clk);
    check("R7 all frames seen", q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule